// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block sits beside the arithmetic datapath of a single-precision floating-point unit. When a two-input operation sees a NaN on either operand, the datapath hands both operands to this block. The block returns the NaN that the operation must produce and raises the invalid-operation flag when a signaling NaN was consumed.

Each operand is classified as quiet, signaling or not a NaN. The classification uses a selectable convention for which significand bit marks a signaling NaN, and can be switched to a mode in which no NaN is signaling. One of three priority policies then chooses the operand to propagate. A chosen signaling operand is quieted. A default-NaN mode replaces the chosen value with a fixed default NaN pattern.

The result is registered. `out_valid` follows `in_valid` by one clock.

Top module: `nan_prop_unit`

## Requirements
- R1: With `snan_hi`=0, an operand with exponent bits [30:23] all ones is quiet when bit 22 is 1. It is signaling when bit 22 is 0 and bits [21:0] are nonzero.
- R2: With `snan_hi`=1, the two tests trade places. Exponent all ones with bit 22 set is signaling. Exponent all ones with bit 22 clear and bits [21:0] nonzero is quiet.
- R3: With `no_snan`=1, every NaN is quiet, no operand is signaling and `invalid` stays 0.
- R4: `invalid` is 1 exactly when at least one operand is signaling. This holds even when default-NaN mode then forces the result.
- R5: The default NaN depends on `policy`. For policy 2 it is 0xFFC00000 when `snan_hi`=0 and 0x7FBFFFFF when `snan_hi`=1. For every other policy it is 0x7FC00000. When `dflt_mode`=1 the result is always this default NaN.
- R6: A chosen signaling operand is quieted before it is output. With `snan_hi`=0, bit 22 is set. With `snan_hi`=1, it is replaced by the default NaN. A chosen non-signaling operand passes unchanged.
- R7: Policy 0, and also code 3, takes the first operand that matches in this order: a if signaling, b if signaling, a if quiet, otherwise b.
- R8: Policy 1 returns a if it is any NaN, otherwise b.
- R9: Policy 2 picks as follows:
  - a signaling NaN paired with a quiet NaN gives the quiet one;
  - two NaNs of the same kind give the one with the larger magnitude (bits [30:0]);
  - on equal magnitude, it gives the one with the smaller raw value, which is the positive one;
  - a lone NaN is returned.
- R10: When neither operand is a NaN, the result is the default NaN and `invalid` is 0. A registered result is always a NaN.
- R11: Reset (synchronous, active high) clears `out_valid`, `result` and `invalid` to 0. `out_valid` equals `in_valid` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| snan_hi | input | 1 | Signaling-bit convention: 1 means bit 22 set marks signaling |
| policy | input | 2 | NaN priority policy (0, 1, 2; 3 behaves as 0) |
| dflt_mode | input | 1 | Force the default NaN as result |
| no_snan | input | 1 | Treat every NaN as quiet |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Propagated NaN |
| invalid | output | 1 | Invalid-operation flag |

## Verification
A misclassified operand shows up at the ports one clock after it is presented. It appears as a wrong `invalid` value, a wrong propagated operand, or a bit 22 left clear. A wrong magnitude comparison or tie-break flips the chosen operand only in policy 2. The sweep therefore covers equal-magnitude pairs of opposite sign. Because there is no state beyond the single output register, every fault is visible in the cycle right after the offending input. No fault can stay hidden across later operations.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;

  typedef enum logic [1:0] {
    POL_SIG_FIRST = 2'd0,
    POL_A_FIRST   = 2'd1,
    POL_MAGNITUDE = 2'd2,
    POL_RSVD      = 2'd3
  } nan_policy_e;

  typedef struct packed {
    logic is_nan;
    logic quiet;
    logic sig;
  } nan_class_t;
endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
  import nanprop_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W
) (
  input  logic [EW+MW:0] val,
  input  logic           snan_hi,
  input  logic           no_snan,
  output nan_class_t     cls
);
  logic exp_ones, top_bit, low_nz, hi_form, lo_form;

  assign exp_ones = &val[MW +: EW];
  assign top_bit  = val[MW-1];
  assign low_nz   = |val[MW-2:0];
  assign hi_form  = exp_ones & top_bit;
  assign lo_form  = exp_ones & ~top_bit & low_nz;

  always_comb begin
    cls.is_nan = hi_form | lo_form;
    if (no_snan) begin
      cls.quiet = hi_form | lo_form;
      cls.sig   = 1'b0;
    end else if (snan_hi) begin
      cls.quiet = lo_form;
      cls.sig   = hi_form;
    end else begin
      cls.quiet = hi_form;
      cls.sig   = lo_form;
    end
  end
endmodule

// File: rtl/nanprop_pick.sv
module nanprop_pick
  import nanprop_pkg::*;
#(
  parameter int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  nan_class_t   ca,
  input  nan_class_t   cb,
  input  logic [1:0]   policy,
  output logic         pick_b
);
  logic a_larger;

  // magnitude first, raw value breaks ties (positive wins)
  assign a_larger = (a[W-2:0] > b[W-2:0]) ||
                    ((a[W-2:0] == b[W-2:0]) && (a < b));

  always_comb begin
    case (nan_policy_e'(policy))
      POL_A_FIRST:   pick_b = ~ca.is_nan;
      POL_MAGNITUDE: begin
        if (ca.sig)        pick_b = cb.sig ? ~a_larger : cb.quiet;
        else if (ca.quiet) pick_b = cb.quiet & ~a_larger;
        else               pick_b = cb.is_nan | ~ca.is_nan;
      end
      default:       pick_b = ~ca.sig & (cb.sig | ~ca.quiet);
    endcase
  end
endmodule

// File: rtl/nan_prop_unit.sv
module nan_prop_unit
  import nanprop_pkg::*;
#(
  parameter int EW         = EXP_W,
  parameter int MW         = MAN_W,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [EW+MW:0]      op_a,
  input  logic [EW+MW:0]      op_b,
  input  logic                snan_hi,
  input  logic [1:0]          policy,
  input  logic                dflt_mode,
  input  logic                no_snan,
  output logic                out_valid,
  output logic [EW+MW:0]      result,
  output logic                invalid
);
  localparam int W = 1 + EW + MW;
  localparam logic [W-1:0] DN_POS_Q = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
  localparam logic [W-1:0] DN_NEG_Q = {1'b1, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
  localparam logic [W-1:0] DN_HI    = {1'b0, {EW{1'b1}}, 1'b0, {(MW-1){1'b1}}};
  localparam logic [W-1:0] QUIET_BIT = {{(EW+1){1'b0}}, 1'b1, {(MW-1){1'b0}}};

  nan_class_t   ca, cb;
  logic         pick_b, chosen_sig, invalid_c;
  logic [W-1:0] dflt, chosen, quieted, result_c;

  nanprop_classify #(.EW(EW), .MW(MW)) u_cls_a (
    .val(op_a), .snan_hi(snan_hi), .no_snan(no_snan), .cls(ca));
  nanprop_classify #(.EW(EW), .MW(MW)) u_cls_b (
    .val(op_b), .snan_hi(snan_hi), .no_snan(no_snan), .cls(cb));

  nanprop_pick #(.W(W)) u_pick (
    .a(op_a), .b(op_b), .ca(ca), .cb(cb), .policy(policy), .pick_b(pick_b));

  always_comb begin
    if (nan_policy_e'(policy) == POL_MAGNITUDE) dflt = snan_hi ? DN_HI : DN_NEG_Q;
    else                                        dflt = DN_POS_Q;
    chosen     = pick_b ? op_b : op_a;
    chosen_sig = pick_b ? cb.sig : ca.sig;
    if (!chosen_sig)  quieted = chosen;
    else if (snan_hi) quieted = dflt;
    else              quieted = chosen | QUIET_BIT;
    if (dflt_mode || !(ca.is_nan || cb.is_nan)) result_c = dflt;
    else                                        result_c = quieted;
    invalid_c = ca.sig | cb.sig;
  end

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          result    <= '0;
          invalid   <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            result  <= result_c;
            invalid <= invalid_c;
          end
        end
      end

      assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      assert_drop_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
      assert_result_nan_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (&result[MW +: EW]) && (|result[MW-1:0]));
      assert_no_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ca.is_nan && !cb.is_nan) |=> !invalid);
      assert_nosnan_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && no_snan) |=> !invalid);
      assert_pick_is_nan_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (ca.is_nan || cb.is_nan)) |-> (pick_b ? cb.is_nan : ca.is_nan));
      assert_dflt_set_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dflt_mode) |=>
          (result == DN_POS_Q || result == DN_NEG_Q || result == DN_HI));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = result_c;
      assign invalid   = invalid_c;
    end
  endgenerate
endmodule

// File: tb/sim_nan_prop_unit.sv
`timescale 1ns/1ps
module sim_nan_prop_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        snan_hi = 1'b0, dflt_mode = 1'b0, no_snan = 1'b0;
  logic [1:0]  policy = 2'd0;
  logic        out_valid, invalid;
  logic [31:0] result;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  nan_prop_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .snan_hi(snan_hi), .policy(policy), .dflt_mode(dflt_mode), .no_snan(no_snan),
    .out_valid(out_valid), .result(result), .invalid(invalid));

  localparam logic [31:0] VALS [14] = '{
    32'h0000_0000, 32'h3F80_0000, 32'h7F80_0000, 32'hFF80_0000,
    32'h7FC0_0000, 32'hFFC0_0000, 32'hFFC0_0001, 32'h7F80_0001,
    32'hFF80_0001, 32'h7FA0_0000, 32'hFFA0_0000, 32'h7FBF_FFFF,
    32'h7FC0_0001, 32'h7FFF_FFFF};

  function automatic logic [32:0] model(logic [31:0] a, logic [31:0] b,
      logic conv, logic [1:0] pol, logic dm, logic ns);
    logic na, nb, ha, hb, qa, qb, sa, sb, selb, alarger, sx;
    logic [31:0] dn, x, r;
    na = (a << 1) > 32'hFF00_0000;  ha = (a << 1) >= 32'hFF80_0000;
    nb = (b << 1) > 32'hFF00_0000;  hb = (b << 1) >= 32'hFF80_0000;
    qa = ns ? na : (conv ? (na && !ha) : ha);
    qb = ns ? nb : (conv ? (nb && !hb) : hb);
    sa = ns ? 1'b0 : (conv ? ha : (na && !ha));
    sb = ns ? 1'b0 : (conv ? hb : (nb && !hb));
    dn = (pol == 2'd2) ? (conv ? 32'h7FBF_FFFF : 32'hFFC0_0000) : 32'h7FC0_0000;
    alarger = ((a & 32'h7FFF_FFFF) > (b & 32'h7FFF_FFFF)) ||
              (((a & 32'h7FFF_FFFF) == (b & 32'h7FFF_FFFF)) && (a < b));
    if (pol == 2'd1)      selb = !na;
    else if (pol == 2'd2) begin
      if (sa && qb)                          selb = 1'b1;
      else if (qa && sb)                     selb = 1'b0;
      else if (na && nb)                     selb = !alarger;
      else                                   selb = !na;
    end else              selb = !sa && (sb || !qa);
    x  = selb ? b : a;
    sx = selb ? sb : sa;
    if (dm || (!na && !nb)) r = dn;
    else if (sx)            r = conv ? dn : (x | 32'h0040_0000);
    else                    r = x;
    return {sa | sb, r};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h (a=%08h b=%08h conv=%0d pol=%0d dm=%0d ns=%0d)",
               tag, act, exp, op_a, op_b, snan_hi, policy, dflt_mode, no_snan);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic apply(logic [31:0] a, logic [31:0] b, logic conv, logic [1:0] pol,
                       logic dm, logic ns);
    op_a = a; op_b = b; snan_hi = conv; policy = pol; dflt_mode = dm; no_snan = ns;
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [32:0] e;
    string tag;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R11 reset result", result, 32'd0);
    chk("R11 reset invalid", {31'd0, invalid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1: conv 0 signaling operand quieted by setting bit 22 (R6)
    apply(32'h7F80_0001, 32'h3F80_0000, 1'b0, 2'd1, 1'b0, 1'b0);
    chk("R1 sNaN quieted", result, 32'h7FC0_0001);
    chk("R1 flag", {31'd0, invalid}, 32'd1);
    chk("R11 out_valid", {31'd0, out_valid}, 32'd1);
    // R2: conv 1 same pattern is quiet, passes unchanged
    apply(32'h7F80_0001, 32'h3F80_0000, 1'b1, 2'd1, 1'b0, 1'b0);
    chk("R2 quiet passes", result, 32'h7F80_0001);
    chk("R2 no flag", {31'd0, invalid}, 32'd0);
    // R6: conv 1 signaling replaced by default
    apply(32'h7FC0_0001, 32'h0000_0000, 1'b1, 2'd1, 1'b0, 1'b0);
    chk("R6 replaced by default", result, 32'h7FC0_0000);
    chk("R6 flag", {31'd0, invalid}, 32'd1);
    // R3: no-signaling mode
    apply(32'h7F80_0001, 32'h7F80_0002, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R3 no quieting", result, 32'h7F80_0001);
    chk("R3 no flag", {31'd0, invalid}, 32'd0);
    // R9 tie-break: positive wins on equal magnitude
    apply(32'hFFC0_0005, 32'h7FC0_0005, 1'b0, 2'd2, 1'b0, 1'b0);
    chk("R9 tie to positive b", result, 32'h7FC0_0005);
    apply(32'h7FC0_0005, 32'hFFC0_0005, 1'b0, 2'd2, 1'b0, 1'b0);
    chk("R9 tie to positive a", result, 32'h7FC0_0005);
    // R4 flag survives default mode
    apply(32'h7F80_0001, 32'h7FC0_0000, 1'b0, 2'd2, 1'b1, 1'b0);
    chk("R5 default conv0 pol2", result, 32'hFFC0_0000);
    chk("R4 flag in default mode", {31'd0, invalid}, 32'd1);

    // exhaustive sweep over operand pairs and all modes
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 4; p++)
        for (int d = 0; d < 2; d++)
          for (int n = 0; n < 2; n++)
            for (int i = 0; i < 14; i++)
              for (int j = 0; j < 14; j++) begin
                apply(VALS[i], VALS[j], c[0], p[1:0], d[0], n[0]);
                e = model(VALS[i], VALS[j], c[0], p[1:0], d[0], n[0]);
                if (d != 0)                                          tag = "R5";
                else if (((VALS[i] << 1) <= 32'hFF00_0000) &&
                         ((VALS[j] << 1) <= 32'hFF00_0000))          tag = "R10";
                else if (p == 1)                                     tag = "R8";
                else if (p == 2)                                     tag = "R9";
                else                                                 tag = "R7";
                chk(tag, result, e[31:0]);
                chk("R4 flag", {31'd0, invalid}, {31'd0, e[32]});
              end

    // R11: out_valid drops one cycle after in_valid
    in_valid = 1'b0;
    @(negedge clk);
    chk("R11 out_valid low", {31'd0, out_valid}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule